// File: doc/BRIEF.md
# Address-Encoded Spin Lock Bank

This block keeps a bank of binary spin locks behind a simple memory-mapped bus. Each lock has one owner entry, which holds the thread ID of the current holder or a reserved "nobody" ID. A thread acquires a lock with a single bus read. The read address carries the lock number, the caller's thread ID and an operation code. The unit tests and updates the owner entry as one indivisible step, then returns the resulting owner as read data. The caller compares the reply with its own ID to learn whether it won. No separate test-and-set write is needed.

A thread gives a lock back by writing its own ID to a release address. One fixed-length controller handles all accesses, one at a time, and each access takes eight clock cycles. The owner entries sit in a small registered-read store. Any request that arrives while the controller is busy is dropped, and the requester must present it again.

Top module: `spinlock_bank`

## Requirements
- R1: Address bits [1:0] carry the operation code, bits [10:2] the thread ID and bits [16:11] the lock number. Bits [31:17] must equal those of the `BASE_ADDR` parameter (default 0x4000_0000). If they do not, the access gets no completion pulse and changes no owner entry.
- R2: After reset every owner entry holds the free value 0x1FF and `bus_done` is low.
- R3: A read with operation 01 (lock) to a free lock stores the requesting thread ID in that lock's entry, and the reply is that ID.
- R4: A lock read to a lock that is already held changes nothing, and the reply is the current holder's ID.
- R5: `bus_done` is a one-cycle pulse. It is high in the cycle that follows the seventh rising edge after the edge that accepted the request, so a request occupies eight cycles. `bus_rdata` carries the zero-extended reply while `bus_done` is high.
- R6: A write with operation 10 (release) frees the lock (entry becomes 0x1FF, reply 0x1FF) when the whole write data word equals the zero-extended current owner ID.
- R7: A release whose write data does not match the current owner leaves the entry unchanged, and the reply is the unchanged owner.
- R8: Thread ID 0x1FF is never granted a lock. Its lock read leaves the entry as it is and replies with the entry's value.
- R9: A request presented while an access is in progress, other than in its completing cycle, is ignored. A request presented in the cycle where `bus_done` is high is accepted on the edge that ends that access.
- R10: A read with operation 00 (query) replies with the current owner and changes nothing. Every other combination also only replies the owner without a change: a read with 10 or 11, and a write with 00, 01 or 11.
- R11: An operation on one lock never alters another lock's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request strobe, sampled on rising edges |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Encoded address: base, lock number, thread ID, operation |
| bus_wdata | input | DATA_W | Write data; for release, the releasing thread ID |
| bus_rdata | output | DATA_W | Reply: owner ID after the operation, zero-extended |
| bus_done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: the completion of one access, and the acceptance of the next. The bench runs its operations back to back. Each new request is driven in exactly the cycle where the previous `bus_done` is high, so every acceptance lands on a completing edge. A separate step presents a lock request in the middle of a busy window. The bench judges that step through the completion pulse, which must come eight cycles after the earlier request and not after the later one, and through a later query, which must show the lock still free. A behavioural owner model in the bench compares `bus_done` on every cycle and compares the reply at every completion.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int TID_W = 9;
  localparam int OP_W  = 2;

  typedef logic [TID_W-1:0] tid_t;

  localparam tid_t NO_OWNER = '1;

  typedef enum logic [OP_W-1:0] {
    OP_QUERY   = 2'b00,
    OP_LOCK    = 2'b01,
    OP_RELEASE = 2'b10,
    OP_RSVD    = 2'b11
  } op_e;

  // Owner value after one access; a reserved requester ID can never win.
  function automatic tid_t owner_after(input logic is_write, input op_e op,
                                       input tid_t cur, input tid_t req_tid,
                                       input logic wdata_ok, input tid_t wr_tid);
    if (!is_write && op == OP_LOCK && cur == NO_OWNER)
      return req_tid;
    if (is_write && op == OP_RELEASE && wdata_ok && cur == wr_tid)
      return NO_OWNER;
    return cur;
  endfunction
endpackage

// File: rtl/spl_owner_store.sv
module spl_owner_store
  import spl_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output tid_t             rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tid_t             wr_data
);
  tid_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= NO_OWNER;
      rd_data <= NO_OWNER;
    end else begin
      rd_data <= mem[rd_idx];
      if (wr_en) mem[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/spl_seq.sv
module spl_seq #(
  parameter int CYCLES = 8,
  localparam int CNT_W = $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hit,
  output logic accept,
  output logic decide,
  output logic finish
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign finish = busy_q && (cnt_q == LAST);
  assign accept = req_hit && (!busy_q || finish);
  assign decide = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R9: a running sequence steps forward undisturbed by new requests
  a_r9_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
  import spl_pkg::*;
#(
  parameter int          NUM_LOCKS  = 64,
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          SEQ_CYCLES = 8,
  parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
  localparam int         LOCK_W     = $clog2(NUM_LOCKS),
  localparam int         FIELD_W    = LOCK_W + TID_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_done
);
  // Address fields
  logic              base_hit;
  logic [LOCK_W-1:0] f_lock;
  tid_t              f_tid;
  op_e               f_op;

  assign base_hit = bus_addr[ADDR_W-1:FIELD_W] == BASE_ADDR[ADDR_W-1:FIELD_W];
  assign f_op     = op_e'(bus_addr[OP_W-1:0]);
  assign f_tid    = bus_addr[OP_W+TID_W-1:OP_W];
  assign f_lock   = bus_addr[FIELD_W-1:OP_W+TID_W];

  // Sequencer events
  logic accept, decide, finish;

  spl_seq #(.CYCLES(SEQ_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_hit(bus_req && base_hit),
    .accept(accept), .decide(decide), .finish(finish)
  );

  // Captured request
  logic [LOCK_W-1:0] req_lock;
  tid_t              req_tid;
  op_e               req_op;
  logic              req_we;
  logic [DATA_W-1:0] req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_lock  <= '0;
      req_tid   <= NO_OWNER;
      req_op    <= OP_QUERY;
      req_we    <= 1'b0;
      req_wdata <= '0;
    end else if (accept) begin
      req_lock  <= f_lock;
      req_tid   <= f_tid;
      req_op    <= f_op;
      req_we    <= bus_we;
      req_wdata <= bus_wdata;
    end
  end

  // Owner store and decision
  tid_t rd_owner, wr_data;
  logic wr_en, wdata_ok;

  assign wdata_ok = req_wdata[DATA_W-1:TID_W] == '0;
  assign wr_data  = owner_after(req_we, req_op, rd_owner, req_tid,
                                wdata_ok, req_wdata[TID_W-1:0]);
  assign wr_en    = decide && (wr_data != rd_owner);

  spl_owner_store #(.DEPTH(NUM_LOCKS)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(req_lock), .rd_data(rd_owner),
    .wr_en(wr_en), .wr_idx(req_lock), .wr_data(wr_data)
  );

  // Reply
  tid_t res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= NO_OWNER;
    else if (decide) res_q <= wr_data;
  end

  assign bus_rdata = {{(DATA_W-TID_W){1'b0}}, res_q};
  assign bus_done  = finish;

  // R5: completion is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);
  // R3: a lock read only ever writes into a free entry
  a_r3_grant_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_op == OP_LOCK) |-> rd_owner == NO_OWNER);
  // R6: a release write always leaves the entry free
  a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_op == OP_RELEASE) |-> wr_data == NO_OWNER);
  // R8: the reserved ID is never stored by a read
  a_r8_no_reserved_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !req_we) |-> wr_data != NO_OWNER);
  // R10: only lock reads and release writes may change an entry
  a_r10_legal_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((req_op == OP_LOCK && !req_we) || (req_op == OP_RELEASE && req_we)));
endmodule

// File: tb/spinlock_bank_test.sv
module spinlock_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] OFF_BASE = 32'h5000_0000;
  localparam int FREE = 511;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_done;

  spinlock_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference model
  int    owner [64];
  bit    m_busy = 0;
  int    m_cnt  = 0;
  int    m_res  = FREE;
  string m_tag  = "R2";

  function automatic logic [31:0] mk_addr(logic [31:0] base, int lock, int tid, int op);
    return {base[31:17], 17'(lock * 2048 + tid * 4 + op)};
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit last;
      last = m_busy && m_cnt == 7;
      if (bus_req && bus_addr[31:17] == BASE[31:17] && (!m_busy || last)) begin
        int lk, tid, op, cur;
        lk  = int'(bus_addr[16:11]);
        tid = int'(bus_addr[10:2]);
        op  = int'(bus_addr[1:0]);
        cur = owner[lk];
        if (!bus_we && op == 1) begin
          if (tid == FREE)      m_tag = "R8";
          else if (cur == FREE) begin owner[lk] = tid; m_tag = "R3"; end
          else                  m_tag = "R4";
        end else if (bus_we && op == 2) begin
          if (bus_wdata == 32'(cur) && cur != FREE) begin
            owner[lk] = FREE; m_tag = "R6";
          end else m_tag = "R7";
        end else m_tag = "R10";
        m_res  = owner[lk];
        m_busy = 1;
        m_cnt  = 0;
      end else if (last) begin
        m_busy = 0;
        m_cnt  = 0;
      end else if (m_busy) m_cnt++;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      exp_done = m_busy && m_cnt == 7;
      checks++;
      if (bus_done !== exp_done) begin
        fails++;
        $display("FAIL R5/R9/R1 done: actual %b expected %b at %0t", bus_done, exp_done, $time);
      end
      if (exp_done) begin
        checks++;
        if (bus_rdata !== 32'(m_res)) begin
          fails++;
          $display("FAIL %s reply: actual %0d expected %0d at %0t", m_tag, bus_rdata, m_res, $time);
        end
      end
    end
  end

  // One-cycle request, starting at a falling edge
  task automatic send(logic we, logic [31:0] base, int lock, int tid, int op, int wd);
    bus_req   = 1'b1;
    bus_we    = we;
    bus_addr  = mk_addr(base, lock, tid, op);
    bus_wdata = 32'(wd);
    @(negedge clk);
    bus_req   = 1'b0;
    bus_we    = 1'b0;
  endtask

  // Full access; returns in the completing cycle so the next send lands on it (R9)
  task automatic access(logic we, int lock, int tid, int op, int wd);
    send(we, BASE, lock, tid, op, wd);
    repeat (7) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) owner[i] = FREE;
    repeat (3) @(negedge clk);
    // R2: reset state, done low
    checks++;
    if (bus_done !== 1'b0) begin
      fails++;
      $display("FAIL R2 done in reset: actual %b expected 0", bus_done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 0, 1, 0, 0);       // R2 query lock 0
    access(0, 63, 1, 0, 0);      // R2 query lock 63
    access(0, 3, 7, 1, 0);       // R3 grant
    access(0, 3, 9, 1, 0);       // R4 held
    access(0, 3, 9, 0, 0);       // R10 query
    access(0, 4, 9, 1, 0);       // R11 other lock
    access(1, 3, 9, 2, 9);       // R7 wrong owner
    access(1, 3, 7, 2, 32'h207); // R7 upper data bits set
    access(1, 3, 7, 2, 7);       // R6 release
    access(0, 3, 9, 1, 0);       // R3 new owner
    access(0, 5, FREE, 1, 0);    // R8 reserved ID
    access(0, 5, 1, 0, 0);       // R8 still free
    access(0, 4, 2, 2, 0);       // R10 read op 10
    access(0, 4, 2, 3, 0);       // R10 read op 11
    access(1, 4, 9, 0, 9);       // R10 write op 00
    access(1, 4, 9, 1, 9);       // R10 write op 01
    access(1, 4, 9, 3, 9);       // R10 write op 11
    access(0, 4, 0, 0, 0);       // R11 lock 4 still held by 9
    // R1: off-base access is not answered and changes nothing
    send(0, OFF_BASE, 6, 1, 1, 0);
    repeat (9) @(negedge clk);
    access(0, 6, 2, 0, 0);
    // R9: request in mid-sequence ignored
    send(0, BASE, 7, 3, 0, 0);
    repeat (2) @(negedge clk);
    send(0, BASE, 8, 3, 1, 0);
    repeat (4) @(negedge clk);
    access(0, 8, 0, 0, 0);       // R9 lock 8 still free
    // R11 sweep over every lock
    for (int i = 0; i < 64; i++) access(0, i, 100 + i, 1, 0);
    for (int i = 0; i < 64; i++) access(0, i, 0, 0, 0);
    access(1, 63, 163, 2, 163);  // R6 top lock
    access(0, 62, 0, 0, 0);      // R11 neighbour untouched
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule